// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs clause-22 management transactions towards an external Ethernet PHY over a two-wire management link. The link is a clock output (`mdc`) and a data line split into `mdio_o`, `mdio_oe` and `mdio_i`. The caller programs a divider select and an enable flag. It then writes a single 32-bit command word that already holds every field of the frame: start code, opcode, PHY address, register address, turnaround code and 16-bit payload.

Once the word is accepted, the block sends thirty-two ones as a preamble. It then shifts the command word out, most significant bit first, with one bit per management clock period. On a read opcode the block releases the data line for the second turnaround bit and the data phase. It samples the sixteen bits returned by the PHY and writes them into the low half of the same command word. Software polls an idle flag in a status register before it issues the next command and before it reads back the result.

Top module: `mdio_frame_master`

## Requirements
- R1: After a synchronous active-low reset, `mdc`=0, `mdio_oe`=0 and `mdio_o`=1. The control, divider and command registers read 0 and the status register reads 32'h4 (idle).
- R2: Register select encoding is 0 = control (bit 4 = port enable), 1 = divider (bits 19:18 = select), 2 = status (bit 2 = idle), 3 = command word. Unlisted bits read 0, and a write to the status select changes nothing.
- R3: The management clock period is 8 system clocks for select 0 and 16×select for selects 1 to 3, so selects 2 and 3 give 32 and 48. `mdc` is low for the first half of each bit period and high for the second half. The ratio is latched when a frame starts, and a divider write during a frame affects only later frames.
- R4: A frame is 64 bit periods: 32 preamble ones, then command bits 31 down to 0. `mdio_o` changes only when `mdc` falls.
- R5: Command bits 31:30 are always 01 and bits 17:16 are always 10, both when sent and when read back, whatever value is written.
- R6: A read opcode (bits 29:28 = 10) drops `mdio_oe` from bit period 47 (the second turnaround bit) to the end of the frame. `mdio_i` is sampled on each rising `mdc` edge of periods 48 to 63 into command bits 15 down to 0.
- R7: Any other opcode keeps `mdio_oe` high for all 64 bit periods.
- R8: Idle reads 0 from the cycle after an accepted command write, for exactly 64×ratio system clocks.
- R9: A command write while a frame is running is ignored. The frame and the stored command word are unaffected.
- R10: With the enable bit clear, a command write starts nothing and is not stored. Clearing enable during a frame aborts it one clock after the control write, giving idle=1, `mdc`=0 and `mdio_oe`=0.
- R11: Between frames `mdc`=0, `mdio_oe`=0 and `mdio_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data for `rd_sel` (combinational) |
| mdio_i | input | 1 | Management data line, input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data line, value driven |
| mdio_oe | output | 1 | Management data line, drive enable |

## Verification
Two pairs of events can fall in the same clock. A register write can land while a frame is in flight, and the end of a frame can coincide with a rising sample or with a control write. The bench places a command write and a divider write in the middle of a 48-clock-per-bit frame. It checks that the frame length, the transmitted bits and the stored word stay as they were, and that the new ratio applies only to the next frame. It also clears the enable bit in the middle of a read. A behavioural model, driven by a time counter since the accepted write, is compared with `mdc`, `mdio_oe`, `mdio_o` and the selected read-back register on every clock.

// File: rtl/mdio_pkg.sv
// Package: shared constants and helpers for the management frame master.
// Assumes clause-22 framing: 32 preamble bits followed by one 32-bit word.
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int WORD_BITS  = 32;
    localparam int FRAME_BITS = PRE_BITS + WORD_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // Bit periods where a read releases the line and captures data
    localparam int RD_RELEASE = PRE_BITS + 15;
    localparam int RD_CAPTURE = PRE_BITS + 16;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_CMD   = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 4;
    localparam int DIV_SEL_LSB   = 18;
    localparam int STAT_IDLE_BIT = 2;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] START_CD = 2'b01;
    localparam logic [1:0] TURN_CD  = 2'b10;

    // Forces the start and turnaround codes into a command word
    function automatic logic [31:0] fix_codes(input logic [31:0] w);
        logic [31:0] r;
        r = w;
        r[31:30] = START_CD;
        r[17:16] = TURN_CD;
        return r;
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
// Module: half-period tick generator for the management clock.
// Emits one tick every (lim+1) clocks while run is high; the counter
// restarts from zero whenever run is low. Assumes lim is held during a run.
module mdio_clk_div #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] lim,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == lim);

    // Counts clocks inside one half period of the management clock
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim));

endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer. Loads a command word on start, then walks
// 64 bit periods: preamble ones, then the word MSB first. It drives data on
// falling management clock edges and samples on rising ones during read data.
// Assumes start is only raised while not busy and en is high.
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] lim_in,
    input  logic             tick,
    input  logic             mdio_i,
    output logic             busy,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic [31:0]      word,
    output logic [CNT_W-1:0] lim
);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] nidx;
    logic             is_rd;
    logic [4:0]       cap_pos;
    logic             nbit;
    logic             n_oe;

    assign nidx    = idx + 1'b1;
    assign cap_pos = 5'd31 - idx[4:0];

    // Selects the value and drive state of the next bit period
    always_comb begin
        if (int'(nidx) < PRE_BITS) nbit = 1'b1;
        else                       nbit = word[5'd31 - nidx[4:0]];
        n_oe = !(is_rd && (int'(nidx) >= RD_RELEASE));
    end

    // Frame state: load, per-half-period advance, capture, end and abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            mdc     <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            idx     <= '0;
            is_rd   <= 1'b0;
            word    <= '0;
            lim     <= '0;
        end else if (busy && !en) begin
            busy    <= 1'b0;
            mdc     <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            mdc     <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
            idx     <= '0;
            is_rd   <= (wdata[29:28] == OP_READ);
            word    <= fix_codes(wdata);
            lim     <= lim_in;
        end else if (busy && tick) begin
            if (!mdc) begin
                mdc <= 1'b1;
                if (is_rd && (int'(idx) >= RD_CAPTURE))
                    word[cap_pos] <= mdio_i;
            end else begin
                mdc <= 1'b0;
                if (int'(idx) == FRAME_BITS - 1) begin
                    busy    <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    idx     <= nidx;
                    mdio_o  <= nbit;
                    mdio_oe <= n_oe;
                end
            end
        end
    end

    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_rd && (int'(idx) >= RD_RELEASE)) |-> !mdio_oe);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc && mdio_o));

    // R4
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en && !tick) |=> ($stable(mdc) && $stable(mdio_o)));

    // R5
    fixed_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (word[31:30] == START_CD && word[17:16] == TURN_CD));

endmodule

// File: rtl/mdio_reg_file.sv
// Module: register port. Holds the enable and divider select, decodes the
// command write into a start pulse and multiplexes read data.
// Assumes the command word itself is stored in the frame sequencer.
module mdio_reg_file
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    input  logic        busy,
    input  logic [31:0] word,
    output logic [31:0] rd_data,
    output logic        en,
    output logic [1:0]  div_sel,
    output logic        start
);

    assign start = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD) && en && !busy;

    // Stores the enable flag and divider select from register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            div_sel <= 2'd0;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_sel) == SEL_CTRL) en      <= wr_data[CTRL_EN_BIT];
            if (reg_sel_e'(wr_sel) == SEL_DIV)  div_sel <= wr_data[DIV_SEL_LSB +: 2];
        end
    end

    // Read data multiplexer
    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_CTRL: rd_data[CTRL_EN_BIT]       = en;
            SEL_DIV:  rd_data[DIV_SEL_LSB +: 2]  = div_sel;
            SEL_STAT: rd_data[STAT_IDLE_BIT]     = !busy;
            default:  rd_data                    = word;
        endcase
    end

endmodule

// File: rtl/mdio_frame_master.sv
// Module: top of the management frame master. Connects the register port,
// the frame sequencer and the clock divider, and maps the divider select to
// a half-period limit. Assumes DIV_BASE and DIV_STEP are even and at least 2.
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int DIV_BASE = 8,
    parameter int DIV_STEP = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);

    localparam int CNT_W = $clog2(DIV_STEP * 2);

    logic             en_q;
    logic [1:0]       div_sel;
    logic             start;
    logic             busy;
    logic [31:0]      word_q;
    logic [CNT_W-1:0] lim_sel;
    logic [CNT_W-1:0] lim_run;
    logic             tick;

    // Maps the divider select to the last count of a half period
    always_comb begin
        if (div_sel == 2'd0) lim_sel = CNT_W'(DIV_BASE / 2 - 1);
        else                 lim_sel = CNT_W'(DIV_STEP * int'(div_sel) / 2 - 1);
    end

    mdio_reg_file u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .busy    (busy),
        .word    (word_q),
        .rd_data (rd_data),
        .en      (en_q),
        .div_sel (div_sel),
        .start   (start)
    );

    mdio_frame_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .start   (start),
        .wdata   (wr_data),
        .lim_in  (lim_sel),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .word    (word_q),
        .lim     (lim_run)
    );

    mdio_clk_div #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .lim   (lim_run),
        .tick  (tick)
    );

    // R9
    busy_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_q[31:16]));

    // R10
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !busy) |=> !busy);

endmodule

// File: tb/mdio_frame_master_tb_top.sv
module mdio_frame_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;
    logic        mdio_i;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Reference model state
    bit          m_busy, m_en, m_rd;
    int          m_t, m_ratio, m_div;
    logic [31:0] m_word;
    logic [15:0] phy_val;

    always #10 clk = ~clk;

    mdio_frame_master dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    function automatic int ratio_of(int sel);
        return (sel == 0) ? 8 : 16 * sel;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        step();
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (rd_data[2] == 1'b0 && n < 20000) begin
            step();
            n++;
        end
    endtask

    task automatic read_cmd(output logic [31:0] v);
        rd_sel = 2'd3;
        step();
        v = rd_data;
        rd_sel = 2'd2;
    endtask

    // Behavioural model: time since the accepted write drives every expectation
    always @(posedge clk) begin : model
        int k;
        bit old_en;
        if (!rst_n) begin
            m_busy = 0; m_en = 0; m_div = 0; m_word = '0;
            m_t = 0; m_ratio = 8; m_rd = 0;
        end else begin
            old_en = m_en;
            if (m_busy && !old_en) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_t++;
                k = m_t / m_ratio;
                if (m_rd && (m_t % m_ratio) == m_ratio / 2 && k >= 48 && k < 64)
                    m_word[63 - k] = mdio_i;
                if (m_t == 64 * m_ratio) m_busy = 0;
            end else if (wr_en && wr_sel == 2'd3 && old_en) begin
                m_busy  = 1;
                m_t     = 0;
                m_ratio = ratio_of(m_div);
                m_word  = wr_data;
                m_word[31:30] = 2'b01;
                m_word[17:16] = 2'b10;
                m_rd    = (wr_data[29:28] == 2'b10);
            end
            if (wr_en && wr_sel == 2'd0) m_en  = wr_data[4];
            if (wr_en && wr_sel == 2'd1) m_div = int'(wr_data[19:18]);
        end
    end

    // Per-clock comparison and PHY response
    always @(negedge clk) begin : compare
        int k;
        bit e_mdc, e_oe, e_o;
        logic [31:0] e_rd;
        k = (m_ratio > 0) ? m_t / m_ratio : 0;
        if (rst_n === 1'b1) begin
            if (m_busy) begin
                e_mdc = (m_t % m_ratio) >= (m_ratio / 2);
                e_oe  = !(m_rd && k >= 47);
                e_o   = (k < 32) ? 1'b1 : m_word[63 - k];
            end else begin
                e_mdc = 0; e_oe = 0; e_o = 1;
            end
            check("R3", "mdc", {31'd0, mdc}, {31'd0, e_mdc});
            check("R6", "mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
            if (e_oe)    check("R4", "mdio_o", {31'd0, mdio_o}, {31'd0, e_o});
            if (!m_busy) check("R11", "mdio_o idle", {31'd0, mdio_o}, 32'd1);
            case (rd_sel)
                2'd0:    e_rd = {27'd0, m_en, 4'd0};
                2'd1:    e_rd = 32'(m_div) << 18;
                2'd2:    e_rd = {29'd0, !m_busy, 2'd0};
                default: e_rd = m_word;
            endcase
            check("R2", "rd_data", rd_data, e_rd);
        end
        if (m_busy && m_rd && k >= 48 && k < 64) mdio_i = phy_val[63 - k];
        else                                   mdio_i = 1'b1;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL R8 watchdog: actual %0d expected < 190000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] fw, fr, fq;
        int n;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rd_sel = 2'd2; mdio_i = 1'b1; phy_val = 16'h3C5A;
        repeat (3) step();
        // R1 reset state
        check("R1", "mdc", {31'd0, mdc}, 32'd0);
        check("R1", "mdio_oe", {31'd0, mdio_oe}, 32'd0);
        check("R1", "mdio_o", {31'd0, mdio_o}, 32'd1);
        check("R1", "status", rd_data, 32'h4);
        rst_n = 1'b1;
        step();

        // R10 command write while disabled is dropped
        wr(2'd3, 32'h5555_1234);
        step();
        check("R10", "idle while disabled", rd_data, 32'h4);
        read_cmd(v);
        check("R10", "word not stored", v, 32'h0);

        // R2 enable and divider read-back; status write has no effect
        wr(2'd0, 32'h0000_0010);
        wr(2'd2, 32'h0000_0000);
        check("R2", "status after write", rd_data, 32'h4);
        rd_sel = 2'd0; step();
        check("R2", "control", rd_data, 32'h10);
        rd_sel = 2'd2;

        // R5/R8 write frame, ratio 8, codes left zero in the written word
        fw = 32'h1000_0000 | (32'd5 << 23) | (32'd3 << 18) | 32'h0000_A5C3;
        wr(2'd3, fw);
        check("R8", "idle after accept", rd_data, 32'h0);
        wait_idle(n);
        check("R8", "frame length div 8", n, 64 * 8);
        check("R11", "mdc after frame", {31'd0, mdc}, 32'd0);
        read_cmd(v);
        check("R5", "forced codes", v, fw | 32'h4002_0000);

        // R6 read frame, ratio 32
        wr(2'd1, 32'd2 << 18);
        fr = 32'h2000_0000 | (32'd17 << 23) | (32'd1 << 18);
        wr(2'd3, fr);
        wait_idle(n);
        check("R3", "frame length div 32", n, 64 * 32);
        read_cmd(v);
        check("R6", "captured data", v, fr | 32'h4002_0000 | 32'h0000_3C5A);

        // R9/R3 write frame at ratio 48 with mid-frame writes
        wr(2'd1, 32'd3 << 18);
        fq = 32'h5000_0000 | (32'd1 << 23) | (32'd9 << 18) | 32'h0000_1234;
        wr(2'd3, fq);
        wr(2'd3, 32'h6000_FFFF);
        wr(2'd1, 32'd1 << 18);
        wait_idle(n);
        check("R9", "frame length with busy writes", n + 4, 64 * 48);
        read_cmd(v);
        check("R9", "word kept", v, (fq & 32'h3FFC_FFFF) | 32'h4002_0000);

        // R3 new ratio applies to the next frame; R7 opcode 00 always drives
        wr(2'd3, 32'h0000_FFFF);
        repeat (47 * 16 + 2) step();
        check("R7", "oe in period 47", {31'd0, mdio_oe}, 32'd1);
        wait_idle(n);
        check("R3", "frame length div 16", n + 47 * 16 + 2, 64 * 16);

        // R10 abort a read by clearing enable
        wr(2'd1, 32'd0);
        wr(2'd3, fr);
        repeat (100) step();
        wr(2'd0, 32'd0);
        step();
        check("R10", "idle after abort", rd_data, 32'h4);
        check("R10", "oe after abort", {31'd0, mdio_oe}, 32'd0);
        check("R10", "mdc after abort", {31'd0, mdc}, 32'd0);
        wr(2'd3, fw);
        step();
        check("R10", "no start while disabled", rd_data, 32'h4);
        repeat (4) step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule